// File: doc/BRIEF.md
# Bus Master Handoff Controller

This block hands a shared system bus between a host and a peripheral's internal DMA engine. When the engine has work it raises a transfer request. The block then requests the bus. The grant input passes through a synchronizer and is sampled twice. The first sample starts a short start-up sequence. A second, confirming sample at the end of that sequence decides whether the block becomes bus master or goes back to waiting.

While master, the block enables its bus-control output drivers. At all other times it drives a combined wait/ready handshake pin used by the host. That pin is driven either high or low, never floated by choice. Its drive is handed over to the bus controls at the moment they are enabled, and taken back when they are released. The pin rests high. In wait mode it is pulled low only for interrupt-acknowledge cycles. In ready mode it is pulled low for any host access that selects the block.

Top module: `bus_handoff`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_req` = 0, `ctl_oe` = 0, `wr_oe` = 1 and `wr_pin` = 1.
- R2: A high `xfer_req` seen at a clock edge while idle raises `bus_req` at that same edge.
- R3: `grant_in` passes through `SYNC_STAGES` flops before use. When `grant_in` has been high for longer than that, `ctl_oe` rises exactly `STARTUP_CYC`+1 clock edges after `bus_req` rises. The first grant sample starts the start-up sequence, and a second sample at its last cycle confirms it.
- R4: If the synchronized grant is low at the confirming sample, the block returns to requesting. `ctl_oe` stays 0 and `bus_req` stays 1 until a later grant is confirmed.
- R5: `wr_oe` is always the complement of `ctl_oe`, so the wait/ready pin and the bus controls never drive at the same time.
- R6: A high `burst_last` seen while master clears `bus_req` and `ctl_oe` at the same edge. While not master, `burst_last` has no effect.
- R7: `wr_pin` is registered with one cycle of latency. It rests high, is held high while master, and comes back high when the bus is released.
- R8: With `ready_mode` = 0 (wait mode), `wr_pin` is low in the cycle after `host_iack` is high. Host reads and writes leave it high.
- R9: With `ready_mode` = 1 (ready mode), `wr_pin` is low in the cycle after `host_cs` & (`host_rd` | `host_wr`) is high. `host_iack` alone, or a strobe without `host_cs`, leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | DMA engine has a burst to move |
| burst_last | input | 1 | Last transfer of the burst completes this cycle |
| grant_in | input | 1 | Asynchronous bus grant, active high |
| host_cs | input | 1 | Host selects the block |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_iack | input | 1 | Interrupt-acknowledge strobe |
| ready_mode | input | 1 | 1 = ready mode, 0 = wait mode |
| bus_req | output | 1 | Bus request |
| ctl_oe | output | 1 | Bus-control output enable (block is master) |
| wr_pin | output | 1 | Wait/ready pin level |
| wr_oe | output | 1 | Wait/ready pin output enable |

## Verification
The bench drops the grant just after the first sample has been taken, so that only the confirming sample sees it low. A design that trusted the first sample would drive the bus without a grant. The bench counts the edges from request to master exactly, which exposes a missing synchronizer stage or a start-up sequence that is too short or too long. It checks that the request and the control enables fall in the same cycle, and that a stray `burst_last` outside mastership changes nothing. In both modes it sends the strobe that must pull the pin low and the strobes that must not, which catches a swapped mode decode. It also strobes while master, which catches a pin that leaves its high rest level while released.

// File: rtl/bmh_pkg.sv
package bmh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_START  = 2'd2,
    ST_MASTER = 2'd3
  } bmh_state_e;

  // Condition under which the wait/ready pin is pulled low
  function automatic logic wr_pull_low(input logic ready_mode, input logic cs,
                                       input logic rd, input logic wr,
                                       input logic iack);
    return ready_mode ? (cs & (rd | wr)) : iack;
  endfunction

  // Edges from bus request to control enable with grant already stable
  function automatic int unsigned master_latency(input int unsigned startup);
    return startup + 1;
  endfunction
endpackage

// File: rtl/bmh_grant_sync.sv
module bmh_grant_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [SYNC_STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/bmh_master_fsm.sv
module bmh_master_fsm
  import bmh_pkg::*;
#(
  parameter int STARTUP_CYC = 3,
  localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic burst_last,
  input  logic gsync,
  output logic bus_req,
  output logic ctl_oe,
  output logic first_sample,
  output logic confirm_ok,
  output logic confirm_fail
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STARTUP_CYC - 1);

  bmh_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic startup_end;

  assign startup_end  = (state_q == ST_START) && (cnt_q == LAST_CNT);
  assign first_sample = (state_q == ST_REQ) && gsync;
  assign confirm_ok   = startup_end && gsync;
  assign confirm_fail = startup_end && !gsync;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:   if (xfer_req) state_d = ST_REQ;
      ST_REQ:    if (first_sample) begin
                   state_d = ST_START;
                   cnt_d   = '0;
                 end
      ST_START:  if (confirm_ok)        state_d = ST_MASTER;
                 else if (confirm_fail) state_d = ST_REQ;
                 else                   cnt_d   = cnt_q + 1'b1;
      ST_MASTER: if (burst_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign bus_req = (state_q != ST_IDLE);
  assign ctl_oe  = (state_q == ST_MASTER);

  // R4
  grant_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> $past(gsync));
  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $fell(ctl_oe));
  // R5
  ctl_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> bus_req);
  // R6
  last_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_oe && bus_req) |=> bus_req);
endmodule

// File: rtl/bmh_wr_pin.sv
module bmh_wr_pin
  import bmh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master_now,
  input  logic ready_mode,
  input  logic host_cs,
  input  logic host_rd,
  input  logic host_wr,
  input  logic host_iack,
  output logic wr_pin,
  output logic wr_oe
);
  logic low_cond;
  logic pin_q;

  assign low_cond = wr_pull_low(ready_mode, host_cs, host_rd, host_wr, host_iack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= master_now | ~low_cond;
  end

  assign wr_pin = pin_q;
  assign wr_oe  = ~master_now;

  // R7
  pin_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_now || !low_cond) |=> wr_pin);
  // R8
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_now && low_cond) |=> !wr_pin);
endmodule

// File: rtl/bus_handoff.sv
module bus_handoff
  import bmh_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STARTUP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic burst_last,
  input  logic grant_in,
  input  logic host_cs,
  input  logic host_rd,
  input  logic host_wr,
  input  logic host_iack,
  input  logic ready_mode,
  output logic bus_req,
  output logic ctl_oe,
  output logic wr_pin,
  output logic wr_oe
);
  logic gsync;
  logic first_sample, confirm_ok, confirm_fail;

  bmh_grant_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(grant_in), .sync_out(gsync)
  );

  bmh_master_fsm #(.STARTUP_CYC(STARTUP_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .burst_last(burst_last),
    .gsync(gsync), .bus_req(bus_req), .ctl_oe(ctl_oe),
    .first_sample(first_sample), .confirm_ok(confirm_ok),
    .confirm_fail(confirm_fail)
  );

  bmh_wr_pin u_wr (
    .clk(clk), .rst_n(rst_n), .master_now(ctl_oe), .ready_mode(ready_mode),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_iack(host_iack), .wr_pin(wr_pin), .wr_oe(wr_oe)
  );

  // R5
  drive_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oe != ctl_oe);
  // R4
  fail_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_fail |=> (!ctl_oe && bus_req));
  // R3
  ok_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_ok |=> ctl_oe);
  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({first_sample, confirm_ok, confirm_fail}));
endmodule

// File: tb/bus_handoff_bench.sv
module bus_handoff_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int SYNC_STAGES = 2;
  localparam int STARTUP_CYC = 3;

  logic clk = 0, rst_n = 0;
  logic xfer_req = 0, burst_last = 0, grant_in = 0;
  logic host_cs = 0, host_rd = 0, host_wr = 0, host_iack = 0, ready_mode = 0;
  logic bus_req, ctl_oe, wr_pin, wr_oe;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_handoff #(.SYNC_STAGES(SYNC_STAGES), .STARTUP_CYC(STARTUP_CYC)) u_bus_handoff (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .burst_last(burst_last),
    .grant_in(grant_in), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_iack(host_iack), .ready_mode(ready_mode),
    .bus_req(bus_req), .ctl_oe(ctl_oe), .wr_pin(wr_pin), .wr_oe(wr_oe)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "bus_req in reset", bus_req, 0);
    check("R1", "ctl_oe in reset", ctl_oe, 0);
    check("R1", "wr_oe in reset", wr_oe, 1);
    check("R1", "wr_pin in reset", wr_pin, 1);
    rst_n = 1;
    step();
    check("R1", "bus_req after reset", bus_req, 0);
    check("R1", "wr_pin after reset", wr_pin, 1);
  endtask

  // Acquire bus with grant already stable; count edges to master
  task automatic t_acquire();
    int n;
    grant_in = 1;
    repeat (SYNC_STAGES + 2) step();
    xfer_req = 1;
    step();
    check("R2", "bus_req one edge after xfer_req", bus_req, 1);
    check("R3", "ctl_oe not yet", ctl_oe, 0);
    n = 0;
    while (!ctl_oe && n < 20) begin
      step();
      n++;
    end
    check("R3", "edges from request to master", n, STARTUP_CYC + 1);
    check("R5", "wr_oe released while master", wr_oe, 0);
    xfer_req = 0;
  endtask

  task automatic t_master_pin();
    ready_mode = 0;
    host_iack = 1;
    step();
    check("R7", "pin held high while master", wr_pin, 1);
    host_iack = 0;
  endtask

  task automatic t_release();
    burst_last = 1;
    step();
    burst_last = 0;
    check("R6", "bus_req dropped", bus_req, 0);
    check("R6", "ctl_oe dropped same edge", ctl_oe, 0);
    check("R5", "wr_oe back", wr_oe, 1);
    check("R7", "pin returns high", wr_pin, 1);
  endtask

  // Grant vanishes after the first sample: confirm must reject
  task automatic t_grant_lost();
    bit bad = 0;
    grant_in = 1;
    repeat (SYNC_STAGES + 2) step();
    xfer_req = 1;
    step();
    grant_in = 0;
    xfer_req = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (ctl_oe || !bus_req) bad = 1;
    end
    check("R4", "no drive after failed confirm", bad, 0);
    burst_last = 1;
    step();
    burst_last = 0;
    check("R6", "burst_last ignored while requesting", bus_req, 1);
    check("R4", "still not master", ctl_oe, 0);
    grant_in = 1;
    for (int i = 0; i < 20 && !ctl_oe; i++) step();
    check("R4", "master after grant returns", ctl_oe, 1);
    t_release();
  endtask

  task automatic t_idle_last();
    burst_last = 1;
    step();
    burst_last = 0;
    check("R6", "burst_last ignored while idle", bus_req, 0);
    check("R6", "ctl_oe stays off while idle", ctl_oe, 0);
  endtask

  task automatic t_wait_mode();
    ready_mode = 0;
    host_cs = 1; host_rd = 1;
    step();
    check("R8", "wait mode read leaves pin high", wr_pin, 1);
    host_rd = 0; host_wr = 1;
    step();
    check("R8", "wait mode write leaves pin high", wr_pin, 1);
    host_wr = 0; host_cs = 0; host_iack = 1;
    step();
    check("R8", "wait mode iack pulls low", wr_pin, 0);
    host_iack = 0;
    step();
    check("R7", "pin rests high again", wr_pin, 1);
  endtask

  task automatic t_ready_mode();
    ready_mode = 1;
    host_cs = 1; host_rd = 1;
    step();
    check("R9", "ready mode read pulls low", wr_pin, 0);
    host_rd = 0; host_wr = 1;
    step();
    check("R9", "ready mode write pulls low", wr_pin, 0);
    host_wr = 0; host_cs = 0; host_rd = 1;
    step();
    check("R9", "strobe without select stays high", wr_pin, 1);
    host_rd = 0; host_iack = 1;
    step();
    check("R9", "iack alone stays high in ready mode", wr_pin, 1);
    host_iack = 0;
    step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_idle_last();
    t_wait_mode();
    t_ready_mode();
    t_acquire();
    t_master_pin();
    t_release();
    t_grant_lost();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule